// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pair Issuer

This block holds the issue decision for a two-wide in-order machine. Each fetch packet has two positions. The left position normally carries an integer-class instruction, which includes loads, stores and branches. The right position normally carries a floating-point operation. The block receives the decoded class and the register fields of both positions, along with a busy flag from each execution pipe. From these it decides, cycle by cycle, which positions issue. It also decides when the packet is fully consumed, so that fetch can present the next one.

Ordering is strict. The right instruction never goes ahead of the left one. If a packet has its classes the wrong way round, it falls back to one instruction per cycle. A packet whose left instruction has issued but whose right instruction has not stays in place. On the following cycles only the right instruction competes.

A one-cycle load delay is enforced in two ways:
- The right partner of a load cannot use the loaded register in the same cycle.
- No instruction can read that register in the cycle right after the load issues.

A branch in the left position with its delay-slot instruction on the right is an ordinary pair.

Top module: `pair_issuer`

## Requirements
- R1: After reset no position counts as already issued and no load delay is pending, so an independent integer + FP packet issues both positions and advances in its first cycle.
- R2: The left instruction issues only when the pipe of its class is free (class 1 = integer pipe, busy when `int_busy` is 1; class 2 = FP pipe, busy when `fp_busy` is 1), it has not issued already, and no pending load delay blocks it.
- R3: The right instruction issues only if the left one issues in the same cycle, has issued earlier for this packet, or is empty.
- R4: When only the left instruction of a packet issues, `pkt_adv` stays 0. The left instruction is not issued again, and the next cycles consider only the right instruction.
- R5: `pkt_adv` is 1 exactly when `pkt_valid` is 1 and both positions are issued or empty. Class codes 0 and 3 are empty. With `pkt_valid` at 0 nothing issues.
- R6: If the left class is FP (2) or the right class is integer (1), the two never issue in the same cycle. The left one goes first.
- R7: A right instruction is held when one of its enabled sources equals the destination of a left instruction issuing in the same cycle. A register id is `{file bit, index}`, with file bit 1 for FP.
- R8: A load (class 1 with `*_load` set and destination enabled) that issues in cycle t blocks every instruction that reads its destination in cycle t+1. In cycle t+2 that instruction may issue.
- R9: A left load whose destination is an FP register pairs with a right FP operation that does not read that register.
- R10: The right instruction issues only when the pipe of its own class is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet is presented |
| l_cls | input | 2 | Left class: 0 empty, 1 integer, 2 FP, 3 empty |
| l_load | input | 1 | Left instruction is a load |
| l_dst_en | input | 1 | Left writes a register |
| l_dst | input | IDX_W+1 | Left destination id |
| l_sa_en | input | 1 | Left source A used |
| l_sa | input | IDX_W+1 | Left source A id |
| l_sb_en | input | 1 | Left source B used |
| l_sb | input | IDX_W+1 | Left source B id |
| r_cls | input | 2 | Right class, same coding |
| r_load | input | 1 | Right instruction is a load |
| r_dst_en | input | 1 | Right writes a register |
| r_dst | input | IDX_W+1 | Right destination id |
| r_sa_en | input | 1 | Right source A used |
| r_sa | input | IDX_W+1 | Right source A id |
| r_sb_en | input | 1 | Right source B used |
| r_sb | input | IDX_W+1 | Right source B id |
| int_busy | input | 1 | Integer pipe cannot accept |
| fp_busy | input | 1 | FP pipe cannot accept |
| iss_l | output | 1 | Left instruction issues this cycle |
| iss_r | output | 1 | Right instruction issues this cycle |
| pkt_adv | output | 1 | Packet consumed; present the next one |

## Verification
The bench builds the block with `IDX_W` = 2, giving four registers per file and eight register ids in total. With so few ids, randomly drawn sources and destinations collide often. Same-cycle read-after-write, load-delay hits, mismatched-class packets and busy pipes therefore occur in nearly every short stretch of a long random run. A reference model built from the requirements checks each cycle of that run, after a directed pass through every rule.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_INT  = 2'd1,
        CLS_FP   = 2'd2,
        CLS_RSVD = 2'd3
    } cls_e;

    typedef struct packed {
        logic go_l;
        logic go_r;
        logic adv;
    } issue_t;

    function automatic logic cls_empty(input cls_e c);
        return (c == CLS_NONE) || (c == CLS_RSVD);
    endfunction

    function automatic logic pipe_ready(input cls_e c, input logic ibusy, input logic fbusy);
        case (c)
            CLS_INT: return !ibusy;
            CLS_FP:  return !fbusy;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic swapped(input cls_e lc, input cls_e rc);
        return (lc == CLS_FP) || (rc == CLS_INT);
    endfunction

endpackage

// File: rtl/reg_match.sv
module reg_match #(
    parameter int REG_W = 6
) (
    input  logic             a_en,
    input  logic [REG_W-1:0] a_id,
    input  logic             b_en,
    input  logic [REG_W-1:0] b_id,
    input  logic             ref_en,
    input  logic [REG_W-1:0] ref_id,
    output logic             hit
);
    always_comb begin
        hit = ref_en && ((a_en && (a_id == ref_id)) || (b_en && (b_id == ref_id)));
    end
endmodule

// File: rtl/load_shadow.sv
module load_shadow #(
    parameter int REG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [REG_W-1:0] fire_id,
    output logic             sh_v,
    output logic [REG_W-1:0] sh_id
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_v  <= 1'b0;
            sh_id <= '0;
        end else begin
            sh_v <= fire;
            if (fire) begin
                sh_id <= fire_id;
            end
        end
    end
endmodule

// File: rtl/pair_hold.sv
module pair_hold (
    input  logic clk,
    input  logic rst,
    input  logic left_go,
    input  logic adv,
    output logic held_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
        end else if (adv) begin
            held_q <= 1'b0;
        end else if (left_go) begin
            held_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pair_issuer.sv
module pair_issuer
    import pair_issue_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pkt_valid,
    input  logic [1:0]     l_cls,
    input  logic           l_load,
    input  logic           l_dst_en,
    input  logic [IDX_W:0] l_dst,
    input  logic           l_sa_en,
    input  logic [IDX_W:0] l_sa,
    input  logic           l_sb_en,
    input  logic [IDX_W:0] l_sb,
    input  logic [1:0]     r_cls,
    input  logic           r_load,
    input  logic           r_dst_en,
    input  logic [IDX_W:0] r_dst,
    input  logic           r_sa_en,
    input  logic [IDX_W:0] r_sa,
    input  logic           r_sb_en,
    input  logic [IDX_W:0] r_sb,
    input  logic           int_busy,
    input  logic           fp_busy,
    output logic           iss_l,
    output logic           iss_r,
    output logic           pkt_adv
);
    localparam int REG_W  = IDX_W + 1;
    localparam int NSLOT  = 2;

    cls_e lc, rc;
    logic l_empty, r_empty, single_mode;
    logic held_q;
    logic sh_v;
    logic [REG_W-1:0] sh_id;
    logic [NSLOT-1:0] sh_hit;
    logic raw_hit;
    logic l_ld, r_ld;
    logic ld_fire;
    logic [REG_W-1:0] ld_id;
    issue_t dec;

    logic [NSLOT-1:0] s_a_en, s_b_en;
    logic [REG_W-1:0] s_a [NSLOT];
    logic [REG_W-1:0] s_b [NSLOT];

    assign lc = cls_e'(l_cls);
    assign rc = cls_e'(r_cls);
    assign l_empty = cls_empty(lc);
    assign r_empty = cls_empty(rc);
    assign single_mode = swapped(lc, rc);

    assign s_a_en = {r_sa_en, l_sa_en};
    assign s_b_en = {r_sb_en, l_sb_en};
    assign s_a[0] = l_sa;
    assign s_a[1] = r_sa;
    assign s_b[0] = l_sb;
    assign s_b[1] = r_sb;

    // one comparator per position against the pending load destination
    for (genvar g = 0; g < NSLOT; g++) begin : g_shadow_cmp
        reg_match #(.REG_W(REG_W)) u_cmp (
            .a_en   (s_a_en[g]),
            .a_id   (s_a[g]),
            .b_en   (s_b_en[g]),
            .b_id   (s_b[g]),
            .ref_en (sh_v),
            .ref_id (sh_id),
            .hit    (sh_hit[g])
        );
    end

    // right sources against left destination, same cycle
    reg_match #(.REG_W(REG_W)) u_raw (
        .a_en   (r_sa_en),
        .a_id   (r_sa),
        .b_en   (r_sb_en),
        .b_id   (r_sb),
        .ref_en (l_dst_en),
        .ref_id (l_dst),
        .hit    (raw_hit)
    );

    pair_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .left_go (dec.go_l),
        .adv     (dec.adv),
        .held_q  (held_q)
    );

    always_comb begin
        logic left_clear;
        dec.go_l = pkt_valid && !held_q && !l_empty
                   && pipe_ready(lc, int_busy, fp_busy) && !sh_hit[0];
        left_clear = held_q || l_empty || (dec.go_l && !single_mode);
        dec.go_r = pkt_valid && !r_empty && left_clear
                   && pipe_ready(rc, int_busy, fp_busy) && !sh_hit[1]
                   && !(dec.go_l && raw_hit);
        dec.adv  = pkt_valid && (held_q || l_empty || dec.go_l)
                   && (r_empty || dec.go_r);
    end

    assign l_ld    = dec.go_l && (lc == CLS_INT) && l_load && l_dst_en;
    assign r_ld    = dec.go_r && (rc == CLS_INT) && r_load && r_dst_en;
    assign ld_fire = l_ld || r_ld;
    assign ld_id   = r_ld ? r_dst : l_dst;

    load_shadow #(.REG_W(REG_W)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .fire    (ld_fire),
        .fire_id (ld_id),
        .sh_v    (sh_v),
        .sh_id   (sh_id)
    );

    assign iss_l   = dec.go_l;
    assign iss_r   = dec.go_r;
    assign pkt_adv = dec.adv;

    a_r3_right_follows_left: assert property (@(posedge clk) disable iff (rst)
        (iss_r && !l_empty) |-> (iss_l || held_q));

    a_r4_no_left_repeat: assert property (@(posedge clk) disable iff (rst)
        (iss_l && !pkt_adv) |=> !iss_l);

    a_r5_adv_needs_valid: assert property (@(posedge clk) disable iff (rst)
        pkt_adv |-> pkt_valid);

    a_r6_swapped_single: assert property (@(posedge clk) disable iff (rst)
        (l_cls == 2'd2 || r_cls == 2'd1) |-> !(iss_l && iss_r));

    a_r7_no_pair_raw: assert property (@(posedge clk) disable iff (rst)
        (iss_l && iss_r && l_dst_en) |->
        !((r_sa_en && r_sa == l_dst) || (r_sb_en && r_sb == l_dst)));

    a_r8_load_gap: assert property (@(posedge clk) disable iff (rst)
        (iss_l && l_cls == 2'd1 && l_load && l_dst_en) |=>
        !(iss_r && ((r_sa_en && r_sa == $past(l_dst)) || (r_sb_en && r_sb == $past(l_dst)))));

    a_r2_int_pipe_free: assert property (@(posedge clk) disable iff (rst)
        (iss_l && l_cls == 2'd1) |-> !int_busy);

    a_r10_fp_pipe_free: assert property (@(posedge clk) disable iff (rst)
        (iss_r && r_cls == 2'd2) |-> !fp_busy);

endmodule

// File: tb/pair_issuer_bench.sv
`timescale 1ns/1ps
module pair_issuer_bench;
    localparam int IDX_W = 2;
    localparam int RW = IDX_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pkt_valid = 1'b0;
    logic [1:0] l_cls = '0, r_cls = '0;
    logic l_load = 0, l_dst_en = 0, l_sa_en = 0, l_sb_en = 0;
    logic r_load = 0, r_dst_en = 0, r_sa_en = 0, r_sb_en = 0;
    logic [RW-1:0] l_dst = '0, l_sa = '0, l_sb = '0;
    logic [RW-1:0] r_dst = '0, r_sa = '0, r_sb = '0;
    logic int_busy = 0, fp_busy = 0;
    logic iss_l, iss_r, pkt_adv;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    bit m_held = 0, m_shv = 0;
    logic [RW-1:0] m_shr = '0;

    always #10 clk = ~clk;

    pair_issuer #(.IDX_W(IDX_W)) u_pair_issuer (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid),
        .l_cls(l_cls), .l_load(l_load), .l_dst_en(l_dst_en), .l_dst(l_dst),
        .l_sa_en(l_sa_en), .l_sa(l_sa), .l_sb_en(l_sb_en), .l_sb(l_sb),
        .r_cls(r_cls), .r_load(r_load), .r_dst_en(r_dst_en), .r_dst(r_dst),
        .r_sa_en(r_sa_en), .r_sa(r_sa), .r_sb_en(r_sb_en), .r_sb(r_sb),
        .int_busy(int_busy), .fp_busy(fp_busy),
        .iss_l(iss_l), .iss_r(iss_r), .pkt_adv(pkt_adv)
    );

    task automatic set_l(input logic [1:0] c, input logic ld, input logic de, input logic [RW-1:0] d,
                         input logic ae, input logic [RW-1:0] a, input logic be, input logic [RW-1:0] b);
        l_cls = c; l_load = ld; l_dst_en = de; l_dst = d;
        l_sa_en = ae; l_sa = a; l_sb_en = be; l_sb = b;
    endtask

    task automatic set_r(input logic [1:0] c, input logic ld, input logic de, input logic [RW-1:0] d,
                         input logic ae, input logic [RW-1:0] a, input logic be, input logic [RW-1:0] b);
        r_cls = c; r_load = ld; r_dst_en = de; r_dst = d;
        r_sa_en = ae; r_sa = a; r_sb_en = be; r_sb = b;
    endtask

    task automatic chk(input string tag, input logic el, input logic er, input logic ea);
        #1;
        total++;
        if (iss_l !== el || iss_r !== er || pkt_adv !== ea) begin
            bad++;
            $display("FAIL %s: got l=%b r=%b adv=%b expected l=%b r=%b adv=%b",
                     tag, iss_l, iss_r, pkt_adv, el, er, ea);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit uses(input logic ae, input logic [RW-1:0] a, input logic be,
                                input logic [RW-1:0] b, input bit en, input logic [RW-1:0] r);
        return en && ((ae && a == r) || (be && b == r));
    endfunction

    function automatic bit free_for(input logic [1:0] c);
        if (c == 2'd1) return !int_busy;
        if (c == 2'd2) return !fp_busy;
        return 0;
    endfunction

    task automatic model_step(output bit el, output bit er, output bit ea);
        bit le, re, lone, rallow;
        le = (l_cls == 2'd0) || (l_cls == 2'd3);
        re = (r_cls == 2'd0) || (r_cls == 2'd3);
        lone = (l_cls == 2'd2) || (r_cls == 2'd1);
        el = pkt_valid && !m_held && !le && free_for(l_cls)
             && !uses(l_sa_en, l_sa, l_sb_en, l_sb, m_shv, m_shr);
        rallow = m_held || le || (el && !lone);
        er = pkt_valid && !re && rallow && free_for(r_cls)
             && !uses(r_sa_en, r_sa, r_sb_en, r_sb, m_shv, m_shr)
             && !(el && uses(r_sa_en, r_sa, r_sb_en, r_sb, l_dst_en, l_dst));
        ea = pkt_valid && (m_held || le || el) && (re || er);
    endtask

    task automatic model_commit(input bit el, input bit er, input bit ea);
        bit lld, rld;
        lld = el && l_cls == 2'd1 && l_load && l_dst_en;
        rld = er && r_cls == 2'd1 && r_load && r_dst_en;
        m_shv = lld || rld;
        if (rld) m_shr = r_dst; else if (lld) m_shr = l_dst;
        if (ea) m_held = 0; else if (el) m_held = 1;
    endtask

    task automatic do_reset();
        rst = 1; pkt_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_held = 0; m_shv = 0; m_shr = '0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit el, er, ea;
        bit newp;
        do_reset();
        // R1: first packet after reset pairs
        pkt_valid = 1;
        set_l(2'd1, 0, 1, 3'b001, 1, 3'b010, 0, '0);
        set_r(2'd2, 0, 1, 3'b101, 1, 3'b110, 1, 3'b111);
        chk("R1 clean pair", 1, 1, 1);
        tick();
        // R2 / R3: integer pipe busy blocks left and hence right
        int_busy = 1;
        chk("R2 int busy blocks left; R3 right waits", 0, 0, 0);
        tick();
        int_busy = 0;
        // R7: right reads the register the left writes
        set_l(2'd1, 0, 1, 3'b110, 1, 3'b001, 0, '0);
        set_r(2'd2, 0, 1, 3'b101, 1, 3'b110, 0, '0);
        chk("R7 same-cycle raw holds right", 1, 0, 0);
        tick();
        chk("R4 held packet issues right only", 0, 1, 1);
        tick();
        // R6: swapped classes
        set_l(2'd2, 0, 1, 3'b100, 1, 3'b101, 0, '0);
        set_r(2'd2, 0, 1, 3'b111, 1, 3'b110, 0, '0);
        chk("R6 left fp single issue", 1, 0, 0);
        tick();
        chk("R6 left fp then right", 0, 1, 1);
        tick();
        set_l(2'd1, 0, 1, 3'b001, 0, '0, 0, '0);
        set_r(2'd1, 0, 1, 3'b010, 0, '0, 0, '0);
        chk("R6 right int single issue", 1, 0, 0);
        tick();
        chk("R6 right int second", 0, 1, 1);
        tick();
        // R5: empties and invalid
        set_l(2'd0, 0, 0, '0, 0, '0, 0, '0);
        set_r(2'd2, 0, 1, 3'b100, 1, 3'b101, 0, '0);
        chk("R5 empty left counts as issued", 0, 1, 1);
        tick();
        set_l(2'd3, 0, 0, '0, 0, '0, 0, '0);
        set_r(2'd0, 0, 0, '0, 0, '0, 0, '0);
        chk("R5 both empty advance", 0, 0, 1);
        tick();
        pkt_valid = 0;
        set_l(2'd1, 0, 1, 3'b001, 0, '0, 0, '0);
        set_r(2'd2, 0, 1, 3'b101, 0, '0, 0, '0);
        chk("R5 invalid packet idle", 0, 0, 0);
        tick();
        pkt_valid = 1;
        // R9: fp load pairs with independent fp op
        set_l(2'd1, 1, 1, 3'b101, 1, 3'b001, 0, '0);
        set_r(2'd2, 0, 1, 3'b100, 1, 3'b111, 0, '0);
        chk("R9 fp load pairs", 1, 1, 1);
        tick();
        // R8: next packet right reads the loaded register
        set_l(2'd1, 0, 1, 3'b010, 1, 3'b000, 0, '0);
        set_r(2'd2, 0, 1, 3'b110, 0, '0, 1, 3'b101);
        chk("R8 load delay blocks next right", 1, 0, 0);
        tick();
        chk("R8 load delay over", 0, 1, 1);
        tick();
        // R8: load with dependent partner spans two cycles
        set_l(2'd1, 1, 1, 3'b101, 1, 3'b001, 0, '0);
        set_r(2'd2, 0, 1, 3'b100, 1, 3'b101, 0, '0);
        chk("R8 partner of load waits", 1, 0, 0);
        tick();
        chk("R8 partner still in delay", 0, 0, 0);
        tick();
        chk("R8 partner issues after delay", 0, 1, 1);
        tick();
        // R8: left of following packet blocked
        set_l(2'd1, 1, 1, 3'b011, 0, '0, 0, '0);
        set_r(2'd0, 0, 0, '0, 0, '0, 0, '0);
        chk("R8 int load alone", 1, 0, 1);
        tick();
        set_l(2'd1, 0, 1, 3'b001, 1, 3'b011, 0, '0);
        set_r(2'd2, 0, 1, 3'b100, 1, 3'b101, 0, '0);
        chk("R8 left reader blocked", 0, 0, 0);
        tick();
        chk("R8 left reader pairs later", 1, 1, 1);
        tick();
        // R10: fp pipe busy
        fp_busy = 1;
        chk("R10 fp busy holds right", 1, 0, 0);
        tick();
        chk("R10 still busy", 0, 0, 0);
        tick();
        fp_busy = 0;
        chk("R10 fp free again", 0, 1, 1);
        tick();

        // random sweep against the model
        do_reset();
        newp = 1;
        for (int i = 0; i < 6000; i++) begin
            if (newp) begin
                set_l(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      RW'($urandom), 1'($urandom_range(0, 1)), RW'($urandom),
                      1'($urandom_range(0, 1)), RW'($urandom));
                set_r(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      RW'($urandom), 1'($urandom_range(0, 1)), RW'($urandom),
                      1'($urandom_range(0, 1)), RW'($urandom));
            end
            int_busy = ($urandom_range(0, 3) == 0);
            fp_busy  = ($urandom_range(0, 3) == 0);
            pkt_valid = m_held ? 1'b1 : ($urandom_range(0, 9) != 0);
            model_step(el, er, ea);
            chk("R2 R3 R4 R5 R6 R7 R8 R10 model", el, er, ea);
            model_commit(el, er, ea);
            newp = ea;
            tick();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule